// File: doc/BRIEF.md
# Bit-Manipulation and Complement Execution Unit

This unit executes two families of instructions from a 16-bit-opcode processor. The first family tests, toggles, clears or sets one bit of an operand. The second family is a bitwise complement of a byte, word or long operand. Address calculation and bus traffic stay outside the unit. The surrounding pipeline supplies these inputs:
- the opcode word;
- the extension word that follows an immediate bit-number form;
- the value of the data register that holds a register-supplied bit number;
- the target data register;
- the memory operand;
- the extra cycle cost of the addressing mode;
- the current condition flags.

When an instruction is presented with `in_valid`, the unit decodes it, computes the new operand value, the new flags and the instruction's cycle count. It presents all results, registered, on the following clock. The pipeline uses `wr_en` to decide whether the result is written back to the register or to memory. Opcodes the unit does not own, and complement opcodes with a bad size code, raise `illegal`.

The flags use a 5-bit vector with X in bit 4, N in bit 3, Z in bit 2, V in bit 1 and C in bit 0. The addressing mode is opcode bits [5:3]. Mode 0 means a data-register target. Any other mode means a memory target.

Top module: `bmx_exec_unit`

## Requirements
- R1: Bit operations are decoded from two forms. In the immediate form, opcode[15:8] = 0000_1000 and the bit number is `ext_word`. In the register form, opcode[15:12] = 0000 and opcode[8] = 1, and the bit number is `bitreg_val`. In both forms, opcode[7:6] selects 00 test, 01 change, 10 clear or 11 set.
- R2: For a data-register target (opcode[5:3] = 000), the operand is all 32 bits of `dreg_val` and the bit number is taken modulo 32.
- R3: For a memory target (opcode[5:3] != 000), the operand is `mem_val[7:0]` and the bit number is taken modulo 8. The upper 24 bits of the result are zero.
- R4: A bit operation sets Z to 1 exactly when the selected bit was 0 before the operation. It copies X, N, V and C from `flags_in`.
- R5: Change inverts the selected bit, clear forces it to 0 and set forces it to 1. All three assert `wr_en`. Test returns the operand unchanged and leaves `wr_en` low.
- R6: Bit-operation cycle counts are as follows. A register target costs 10 in the immediate form and 6 in the register form. A memory target costs 8 + `ea_cycles` in the immediate form and 4 + `ea_cycles` in the register form.
- R7: Complement is decoded from opcode[15:8] = 0100_0110, with opcode[7:6] as the size (00 byte, 01 word, 10 long). The operand is `dreg_val` for mode 000 and `mem_val` otherwise. The low byte, low word or all 32 bits are inverted, the bits above the size are kept, and `wr_en` is 1.
- R8: Complement clears V and C and keeps X. It sets N from the top bit of the inverted field. It sets Z when the inverted field is zero.
- R9: Complement cycle counts are as follows. A register target costs 4 for byte or word and 8 for long. A memory target costs 8 + `ea_cycles` for byte or word and 12 + `ea_cycles` for long.
- R10: A complement with size 11, or any opcode outside R1 and R7, sets `illegal` to 1. It also forces `wr_en` = 0, `result` = 0 and `cycles` = 0, and makes `flags_out` equal to `flags_in`.
- R11: Every output is registered.
  - `out_valid` is `in_valid` delayed by one clock.
  - `wr_en` is never high without `out_valid`.
  - While in reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction strobe |
| opcode | input | 16 | Opcode word |
| ext_word | input | 16 | Bit number for immediate forms |
| bitreg_val | input | 32 | Bit number for register forms |
| dreg_val | input | 32 | Data-register operand |
| mem_val | input | 32 | Memory operand, right-aligned |
| ea_cycles | input | 8 | Addressing-mode cycle cost |
| flags_in | input | 5 | Current flags {X,N,Z,V,C} |
| out_valid | output | 1 | Results valid |
| result | output | 32 | Value to write back |
| wr_en | output | 1 | Write-back enable |
| flags_out | output | 5 | Updated flags {X,N,Z,V,C} |
| cycles | output | 8 | Cycle count of the instruction |
| illegal | output | 1 | Illegal opcode |

## Verification
Each of the four bit operations is applied to both target kinds and in both bit-number forms:
- Bit numbers above 31, and register values with high bits set, show whether the modulo-32 reduction for registers and the modulo-8 reduction for memory are applied to the right target.
- Operands whose selected bit is already 0, and others where it is already 1, separate the Z rule from the effect of the operation.

Complement is run at every size and on both target kinds, with operands such as 0xFF in the low byte and all-zero words. These values separate inversion of the field alone from inversion of the whole register, and exercise the N and Z corner values. Flag inputs with X, N, V and C all set show which flags each family preserves. Back-to-back strobes show that the output timing is one clock after the strobe.

// File: rtl/bmx_pkg.sv
package bmx_pkg;

  typedef enum logic [1:0] {
    BOP_TEST = 2'b00,
    BOP_CHG  = 2'b01,
    BOP_CLR  = 2'b10,
    BOP_SET  = 2'b11
  } bop_e;

  typedef enum logic [1:0] {
    CLS_NONE    = 2'b00,
    CLS_BIT_IMM = 2'b01,
    CLS_BIT_REG = 2'b10,
    CLS_CMPL    = 2'b11
  } cls_e;

  typedef enum logic [1:0] {
    SZ_B   = 2'b00,
    SZ_W   = 2'b01,
    SZ_L   = 2'b10,
    SZ_BAD = 2'b11
  } sz_e;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

  // Base cycle costs
  localparam int unsigned BIT_IMM_REG_CYC = 10;
  localparam int unsigned BIT_REG_REG_CYC = 6;
  localparam int unsigned BIT_IMM_MEM_CYC = 8;
  localparam int unsigned BIT_REG_MEM_CYC = 4;
  localparam int unsigned CMPL_BW_REG_CYC = 4;
  localparam int unsigned CMPL_L_REG_CYC  = 8;
  localparam int unsigned CMPL_BW_MEM_CYC = 8;
  localparam int unsigned CMPL_L_MEM_CYC  = 12;

endpackage

// File: rtl/bmx_decode.sv
module bmx_decode
  import bmx_pkg::*;
(
  input  logic [15:0] opcode,
  output cls_e        cls,
  output bop_e        bop,
  output sz_e         sz,
  output logic        reg_tgt,
  output logic        illegal
);

  always_comb begin
    bop     = bop_e'(opcode[7:6]);
    sz      = sz_e'(opcode[7:6]);
    reg_tgt = (opcode[5:3] == 3'b000);
    casez (opcode)
      16'b0000_1000_????_????: cls = CLS_BIT_IMM;
      16'b0000_???1_????_????: cls = CLS_BIT_REG;
      16'b0100_0110_????_????: cls = CLS_CMPL;
      default:                 cls = CLS_NONE;
    endcase
    illegal = (cls == CLS_NONE) || ((cls == CLS_CMPL) && (sz == SZ_BAD));
  end

endmodule

// File: rtl/bmx_bitop.sv
module bmx_bitop
  import bmx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CYC_W  = 8
) (
  input  bop_e              bop,
  input  logic              imm_form,
  input  logic              reg_tgt,
  input  logic [DATA_W-1:0] bitnum,
  input  logic [DATA_W-1:0] dreg,
  input  logic [7:0]        mem_byte,
  input  logic [CYC_W-1:0]  ea_cyc,
  input  ccr_t              flags_in,
  output logic [DATA_W-1:0] result,
  output logic              we,
  output ccr_t              flags,
  output logic [CYC_W-1:0]  cycles
);

  localparam int unsigned IDX_W = $clog2(DATA_W);

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] opnd;
  logic [DATA_W-1:0] mask;
  logic              was_zero;

  // Operand and bit-index selection by target kind
  always_comb begin
    if (reg_tgt) begin
      idx  = IDX_W'(bitnum % DATA_W);
      opnd = dreg;
    end else begin
      idx  = IDX_W'(bitnum % 8);
      opnd = DATA_W'(mem_byte);
    end
    mask     = DATA_W'(1) << idx;
    was_zero = ((opnd & mask) == '0);
  end

  // Operation
  always_comb begin
    result = opnd;
    we     = 1'b0;
    case (bop)
      BOP_TEST: begin result = opnd;         we = 1'b0; end
      BOP_CHG:  begin result = opnd ^ mask;  we = 1'b1; end
      BOP_CLR:  begin result = opnd & ~mask; we = 1'b1; end
      BOP_SET:  begin result = opnd | mask;  we = 1'b1; end
      default:  begin result = opnd;         we = 1'b0; end
    endcase
    flags   = flags_in;
    flags.z = was_zero;
  end

  // Cycle cost
  always_comb begin
    if (reg_tgt)
      cycles = imm_form ? CYC_W'(BIT_IMM_REG_CYC) : CYC_W'(BIT_REG_REG_CYC);
    else
      cycles = (imm_form ? CYC_W'(BIT_IMM_MEM_CYC) : CYC_W'(BIT_REG_MEM_CYC)) + ea_cyc;
  end

endmodule

// File: rtl/bmx_compl.sv
module bmx_compl
  import bmx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CYC_W  = 8
) (
  input  sz_e               sz,
  input  logic              reg_tgt,
  input  logic [DATA_W-1:0] dreg,
  input  logic [DATA_W-1:0] mem,
  input  logic [CYC_W-1:0]  ea_cyc,
  input  ccr_t              flags_in,
  output logic [DATA_W-1:0] result,
  output ccr_t              flags,
  output logic [CYC_W-1:0]  cycles
);

  localparam int unsigned HALF_W = 16;
  localparam int unsigned BYTE_W = 8;

  logic [DATA_W-1:0] opnd;
  logic [DATA_W-1:0] inv;
  logic              top_bit;
  logic              fld_zero;
  logic              is_long;

  always_comb begin
    opnd    = reg_tgt ? dreg : mem;
    inv     = ~opnd;
    is_long = (sz == SZ_L);
    case (sz)
      SZ_B: begin
        result   = {opnd[DATA_W-1:BYTE_W], inv[BYTE_W-1:0]};
        top_bit  = inv[BYTE_W-1];
        fld_zero = (inv[BYTE_W-1:0] == '0);
      end
      SZ_W: begin
        result   = {opnd[DATA_W-1:HALF_W], inv[HALF_W-1:0]};
        top_bit  = inv[HALF_W-1];
        fld_zero = (inv[HALF_W-1:0] == '0);
      end
      default: begin
        result   = inv;
        top_bit  = inv[DATA_W-1];
        fld_zero = (inv == '0);
      end
    endcase
    flags   = flags_in;
    flags.n = top_bit;
    flags.z = fld_zero;
    flags.v = 1'b0;
    flags.c = 1'b0;
  end

  always_comb begin
    if (reg_tgt)
      cycles = is_long ? CYC_W'(CMPL_L_REG_CYC) : CYC_W'(CMPL_BW_REG_CYC);
    else
      cycles = (is_long ? CYC_W'(CMPL_L_MEM_CYC) : CYC_W'(CMPL_BW_MEM_CYC)) + ea_cyc;
  end

endmodule

// File: rtl/bmx_exec_unit.sv
module bmx_exec_unit
  import bmx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned EXT_W  = 16,
  parameter int unsigned CYC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [15:0]       opcode,
  input  logic [EXT_W-1:0]  ext_word,
  input  logic [DATA_W-1:0] bitreg_val,
  input  logic [DATA_W-1:0] dreg_val,
  input  logic [DATA_W-1:0] mem_val,
  input  logic [CYC_W-1:0]  ea_cycles,
  input  logic [4:0]        flags_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic [4:0]        flags_out,
  output logic [CYC_W-1:0]  cycles,
  output logic              illegal
);

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  // Decode
  cls_e dec_cls;
  bop_e dec_bop;
  sz_e  dec_sz;
  logic dec_reg_tgt;
  logic dec_illegal;

  bmx_decode u_decode (
    .opcode  (opcode),
    .cls     (dec_cls),
    .bop     (dec_bop),
    .sz      (dec_sz),
    .reg_tgt (dec_reg_tgt),
    .illegal (dec_illegal)
  );

  logic              is_imm, is_bit, is_cmpl;
  logic [DATA_W-1:0] bit_num;
  ccr_t              ccr_in;

  assign is_imm  = (dec_cls == CLS_BIT_IMM);
  assign is_bit  = (dec_cls == CLS_BIT_IMM) || (dec_cls == CLS_BIT_REG);
  assign is_cmpl = (dec_cls == CLS_CMPL);
  assign bit_num = is_imm ? DATA_W'(ext_word) : bitreg_val;
  assign ccr_in  = ccr_t'(flags_in);

  // Bit operations
  logic [DATA_W-1:0] b_result;
  logic              b_we;
  ccr_t              b_flags;
  logic [CYC_W-1:0]  b_cycles;

  bmx_bitop #(.DATA_W(DATA_W), .CYC_W(CYC_W)) u_bitop (
    .bop      (dec_bop),
    .imm_form (is_imm),
    .reg_tgt  (dec_reg_tgt),
    .bitnum   (bit_num),
    .dreg     (dreg_val),
    .mem_byte (mem_val[7:0]),
    .ea_cyc   (ea_cycles),
    .flags_in (ccr_in),
    .result   (b_result),
    .we       (b_we),
    .flags    (b_flags),
    .cycles   (b_cycles)
  );

  // Complement
  logic [DATA_W-1:0] c_result;
  ccr_t              c_flags;
  logic [CYC_W-1:0]  c_cycles;

  bmx_compl #(.DATA_W(DATA_W), .CYC_W(CYC_W)) u_compl (
    .sz       (dec_sz),
    .reg_tgt  (dec_reg_tgt),
    .dreg     (dreg_val),
    .mem      (mem_val),
    .ea_cyc   (ea_cycles),
    .flags_in (ccr_in),
    .result   (c_result),
    .flags    (c_flags),
    .cycles   (c_cycles)
  );

  // Next-state selection
  logic [DATA_W-1:0] nxt_result;
  logic              nxt_we;
  ccr_t              nxt_flags;
  logic [CYC_W-1:0]  nxt_cycles;

  always_comb begin
    nxt_result = '0;
    nxt_we     = 1'b0;
    nxt_flags  = ccr_in;
    nxt_cycles = '0;
    if (!dec_illegal) begin
      if (is_bit) begin
        nxt_result = b_result;
        nxt_we     = b_we;
        nxt_flags  = b_flags;
        nxt_cycles = b_cycles;
      end else if (is_cmpl) begin
        nxt_result = c_result;
        nxt_we     = 1'b1;
        nxt_flags  = c_flags;
        nxt_cycles = c_cycles;
      end
    end
  end

  // Output registers
  logic              valid_q, we_q, ill_q;
  logic [DATA_W-1:0] result_q;
  ccr_t              flags_q;
  logic [CYC_W-1:0]  cycles_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q  <= 1'b0;
      we_q     <= 1'b0;
      ill_q    <= 1'b0;
      result_q <= '0;
      flags_q  <= '0;
      cycles_q <= '0;
    end else begin
      valid_q <= in_valid;
      we_q    <= in_valid & nxt_we;
      if (in_valid) begin
        ill_q    <= dec_illegal;
        result_q <= nxt_result;
        flags_q  <= nxt_flags;
        cycles_q <= nxt_cycles;
      end
    end
  end

  assign out_valid = valid_q;
  assign wr_en     = we_q;
  assign illegal   = ill_q;
  assign result    = result_q;
  assign flags_out = flags_q;
  assign cycles    = cycles_q;

  // Assertions
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);

  a_r11_valid_drops: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);

  a_r11_we_needs_valid: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |-> out_valid);

  a_r10_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && dec_illegal) |=> (illegal && !wr_en && flags_out == $past(flags_in)));

  a_r5_test_no_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && is_bit && dec_bop == BOP_TEST) |=> !wr_en);

  a_r4_bit_keeps_xnvc: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && is_bit) |=>
      (flags_out[4:3] == $past(flags_in[4:3]) && flags_out[1:0] == $past(flags_in[1:0])));

  a_r8_compl_clears_vc: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && is_cmpl && !dec_illegal) |=>
      (flags_out[1:0] == 2'b00 && flags_out[4] == $past(flags_in[4]) && wr_en));

endmodule

// File: tb/test_bmx_exec_unit.sv
`timescale 1ns/1ps
module test_bmx_exec_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] opcode;
  logic [15:0] ext_word;
  logic [31:0] bitreg_val, dreg_val, mem_val;
  logic [7:0]  ea_cycles;
  logic [4:0]  flags_in;
  logic        out_valid, wr_en, illegal;
  logic [31:0] result;
  logic [4:0]  flags_out;
  logic [7:0]  cycles;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bmx_exec_unit i_bmx_exec_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .ext_word(ext_word), .bitreg_val(bitreg_val), .dreg_val(dreg_val),
    .mem_val(mem_val), .ea_cycles(ea_cycles), .flags_in(flags_in),
    .out_valid(out_valid), .result(result), .wr_en(wr_en),
    .flags_out(flags_out), .cycles(cycles), .illegal(illegal)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Expected behaviour derived from the requirements
  task automatic model(input logic [15:0] opc, input logic [15:0] ext, input logic [31:0] breg,
                       input logic [31:0] dreg, input logic [31:0] mem, input logic [7:0] ea,
                       input logic [4:0] fl, output logic [31:0] r, output logic we,
                       output logic [4:0] fo, output logic [7:0] cy, output logic ill);
    logic        regt;
    logic [31:0] bn, opnd, m;
    int          pos;
    regt = (opc[5:3] == 3'b000);
    r = 32'h0; we = 1'b0; fo = fl; cy = 8'd0; ill = 1'b0;
    if (opc[15:8] == 8'h08 || (opc[15:12] == 4'h0 && opc[8])) begin
      bn   = (opc[15:8] == 8'h08) ? {16'h0, ext} : breg;
      pos  = regt ? int'(bn[4:0]) : int'(bn[2:0]);
      opnd = regt ? dreg : {24'h0, mem[7:0]};
      m    = 32'h1 << pos;
      fo[2] = (opnd[pos] == 1'b0);
      case (opc[7:6])
        2'b00: begin r = opnd; we = 1'b0; end
        2'b01: begin r = opnd ^ m; we = 1'b1; end
        2'b10: begin r = opnd & ~m; we = 1'b1; end
        default: begin r = opnd | m; we = 1'b1; end
      endcase
      if (opc[15:8] == 8'h08) cy = regt ? 8'd10 : 8'd8 + ea;
      else                    cy = regt ? 8'd6  : 8'd4 + ea;
    end else if (opc[15:8] == 8'h46 && opc[7:6] != 2'b11) begin
      opnd = regt ? dreg : mem;
      we = 1'b1;
      fo[1] = 1'b0; fo[0] = 1'b0;
      case (opc[7:6])
        2'b00: begin r = {opnd[31:8], ~opnd[7:0]};   fo[3] = r[7];  fo[2] = (r[7:0] == 0); end
        2'b01: begin r = {opnd[31:16], ~opnd[15:0]}; fo[3] = r[15]; fo[2] = (r[15:0] == 0); end
        default: begin r = ~opnd;                    fo[3] = r[31]; fo[2] = (r == 0); end
      endcase
      if (opc[7:6] == 2'b10) cy = regt ? 8'd8 : 8'd12 + ea;
      else                   cy = regt ? 8'd4 : 8'd8 + ea;
    end else begin
      ill = 1'b1;
    end
  endtask

  // Drive one instruction, check the registered response one clock later
  task automatic run_op(input string tag, input logic [15:0] opc, input logic [15:0] ext,
                        input logic [31:0] breg, input logic [31:0] dreg, input logic [31:0] mem,
                        input logic [7:0] ea, input logic [4:0] fl);
    logic [31:0] er; logic ew; logic [4:0] ef; logic [7:0] ec; logic ei;
    model(opc, ext, breg, dreg, mem, ea, fl, er, ew, ef, ec, ei);
    @(negedge clk);
    opcode = opc; ext_word = ext; bitreg_val = breg; dreg_val = dreg;
    mem_val = mem; ea_cycles = ea; flags_in = fl; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R11 out_valid"}, {31'h0, out_valid}, 32'h1);
    chk({tag, " result"},        result,              er);
    chk({tag, " wr_en"},         {31'h0, wr_en},      {31'h0, ew});
    chk({tag, " flags"},         {27'h0, flags_out},  {27'h0, ef});
    chk({tag, " cycles"},        {24'h0, cycles},     {24'h0, ec});
    chk({tag, " illegal"},       {31'h0, illegal},    {31'h0, ei});
  endtask

  task automatic t_reset;
    chk("R11 reset out_valid", {31'h0, out_valid}, 32'h0);
    chk("R11 reset wr_en",     {31'h0, wr_en},     32'h0);
    chk("R11 reset result",    result,             32'h0);
    chk("R11 reset flags",     {27'h0, flags_out}, 32'h0);
    chk("R11 reset cycles",    {24'h0, cycles},    32'h0);
    chk("R11 reset illegal",   {31'h0, illegal},   32'h0);
  endtask

  task automatic t_bit_reg_target;
    run_op("R1 R2 R5 test set-bit",    16'h0800, 16'd5,  32'h0, 32'h0000_0020, 32'h0, 8'd3, 5'b11011);
    run_op("R2 R4 test clear-bit",     16'h0800, 16'd6,  32'h0, 32'h0000_0020, 32'h0, 8'd3, 5'b00000);
    run_op("R2 R5 chg bit 37 mod 32",  16'h0840, 16'd37, 32'h0, 32'h0000_0020, 32'h0, 8'd3, 5'b11111);
    run_op("R2 R5 clr bit 31",         16'h0880, 16'd31, 32'h0, 32'h8000_0001, 32'h0, 8'd3, 5'b01010);
    run_op("R5 R6 set bit 0",          16'h08C0, 16'd0,  32'h0, 32'h0000_0000, 32'h0, 8'd3, 5'b10001);
  endtask

  task automatic t_bit_mem_target;
    run_op("R3 R6 set mem bit 10 mod 8", 16'h08D0, 16'd10, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FF11, 8'd4, 5'b11011);
    run_op("R3 R5 chg mem bit 7",        16'h0868, 16'd7,  32'h0, 32'h0, 32'h0000_0080, 8'd6, 5'b00100);
  endtask

  task automatic t_bit_reg_form;
    run_op("R1 R6 reg-form chg bit 33", 16'h0F40, 16'h0, 32'd33,        32'h0000_0003, 32'h0, 8'd2, 5'b10101);
    run_op("R1 R3 reg-form clr mem",    16'h0791, 16'h0, 32'hFFFF_FFF9, 32'h0, 32'h0000_00AB, 8'd5, 5'b01110);
    run_op("R1 R5 reg-form test mem",   16'h0318, 16'h0, 32'd2,         32'h0, 32'h0000_0004, 8'd1, 5'b11011);
  endtask

  task automatic t_compl;
    run_op("R7 R8 R9 cmpl byte reg",  16'h4600, 16'h0, 32'h0, 32'h1234_56FF, 32'h0, 8'd3, 5'b11111);
    run_op("R7 R8 cmpl word reg",     16'h4640, 16'h0, 32'h0, 32'hABCD_0000, 32'h0, 8'd3, 5'b00111);
    run_op("R7 R9 cmpl long reg",     16'h4680, 16'h0, 32'h0, 32'h0F0F_0F0F, 32'h0, 8'd3, 5'b10011);
    run_op("R7 R9 cmpl long mem",     16'h4690, 16'h0, 32'h0, 32'h0, 32'hFFFF_FFFF, 8'd4, 5'b10011);
    run_op("R7 R9 cmpl word mem",     16'h4658, 16'h0, 32'h0, 32'h0, 32'h0000_8001, 8'd2, 5'b00000);
  endtask

  task automatic t_illegal;
    run_op("R10 cmpl size 11",   16'h46C0, 16'h0, 32'h0, 32'h1234_5678, 32'h0, 8'd3, 5'b10110);
    run_op("R10 foreign opcode", 16'h4E71, 16'h0, 32'h0, 32'h1234_5678, 32'h0, 8'd3, 5'b01001);
  endtask

  task automatic t_timing;
    run_op("R11 back-to-back a", 16'h08C0, 16'd4, 32'h0, 32'h0, 32'h0, 8'd0, 5'b00000);
    @(negedge clk);
    chk("R11 out_valid drops", {31'h0, out_valid}, 32'h0);
    chk("R11 wr_en drops",     {31'h0, wr_en},     32'h0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; opcode = '0; ext_word = '0; bitreg_val = '0;
    dreg_val = '0; mem_val = '0; ea_cycles = '0; flags_in = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_bit_reg_target();
    t_bit_mem_target();
    t_bit_reg_form();
    t_compl();
    t_illegal();
    t_timing();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule